// File: doc/BRIEF.md
# Bank Address Demultiplexer and Bus Glue

This block sits between a 6502-family processor with a 24-bit address space and its memory and I/O. During the low half of each PHI2 cycle the processor puts the top address byte (the bank) on its data bus. A level-sensitive latch, open while PHI2 is low and closed while it is high, recovers that byte. The block then presents the full 24-bit address, so bank bits are valid and chip-select decoding has settled before PHI2 rises. An edge-captured register would only deliver the bank after the rising edge, which is too late.

A data path joins the processor data bus to the peripheral data bus. It is enabled only while PHI2 is high, so a slow peripheral still driving after PHI2 falls cannot collide with the next bank byte. Its direction follows RWB. The memory map decodes 512 KB of RAM (banks 0x00 to 0x07) and carves out one 256-byte I/O window at 0x00:7F00 to 0x00:7FFF for a single interface-adapter device. The I/O select and the active-low read and write strobes are qualified by the valid-address outputs. A parameter picks either VDA OR VPA or VDA alone as the qualifier. The RAM select is plain address decode.

Each bus cycle falls into one of three kinds: dummy (no qualifier), read (qualifier with RWB high) or write (qualifier with RWB low). A strobe may go low only during PHI2 high of a read or write cycle. Each address falls into one of three regions: I/O window, RAM or unmapped. The I/O window takes priority over RAM. There is no reset: the bank becomes defined in the first PHI2-low phase, before any vector fetch.

Top module: `bank_bus_glue`

## Requirements
- R1: While phi2 is low, addr_out[23:16] equals cpu_d_in, and addr_out[15:0] always equals addr_lo.
- R2: While phi2 is high, addr_out[23:16] holds the value cpu_d_in had when phi2 rose, even if cpu_d_in changes.
- R3: periph_oe is 1 only while phi2 is high. cpu_d_oe is 1 only while phi2 is high and rwb is 1.
- R4: periph_dir_out is 1 (processor toward peripheral) when rwb is 0 and 0 when rwb is 1. periph_d_out carries cpu_d_in and cpu_d_out carries periph_d_in.
- R5: io_cs_n is 0 only for an I/O window address in a qualified cycle. With the default QUAL_VDA_ONLY=0 the qualifier is vda OR vpa. With QUAL_VDA_ONLY=1 it is vda alone.
- R6: A cycle with vda=0 and vpa=0 never drives io_cs_n, rd_n or wr_n low.
- R7: rd_n is 0 exactly when phi2, rwb and the qualifier are all 1. wr_n is 0 exactly when phi2 and the qualifier are 1 and rwb is 0.
- R8: ram_cs_n is 0 for banks 0x00 to 0x07 except the window 0x00:7F00 to 0x00:7FFF, and 1 for every other address.
- R9: Back-to-back write cycles each produce their own wr_n pulse, with wr_n returning to 1 during the phi2-low phase between them.
- R10: With no reset, the bank output is defined from the first phi2-low phase onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | Processor phase-2 clock |
| rwb | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Valid data address from processor |
| vpa | input | 1 | Valid program address from processor |
| addr_lo | input | 16 | Low address bits A0–A15 |
| cpu_d_in | input | 8 | Processor data bus as driven by the processor |
| cpu_d_out | output | 8 | Data returned to the processor |
| cpu_d_oe | output | 1 | Enable for driving cpu_d_out onto the processor bus |
| addr_out | output | 24 | Full demultiplexed address |
| periph_d_in | input | 8 | Data driven by memory or I/O |
| periph_d_out | output | 8 | Data driven toward memory or I/O |
| periph_oe | output | 1 | Data path enable |
| periph_dir_out | output | 1 | 1 = toward peripheral, 0 = toward processor |
| ram_cs_n | output | 1 | RAM select, active low |
| io_cs_n | output | 1 | I/O device select, active low |
| rd_n | output | 1 | Qualified read strobe, active low |
| wr_n | output | 1 | Qualified write strobe, active low |

## Verification
The assertions assume that vda, vpa, rwb and addr_lo stay steady through each PHI2-high phase, as the processor holds them. The stimulus changes them only in the low phase. They also assume that both strobes are never demanded at once, which holds because rwb is a single wire. The stimulus changes the processor data bus inside the high phase only to mimic write data replacing the bank byte, and it never moves the data bus and PHI2 at the same instant.

// File: rtl/bbg_pkg.sv
package bbg_pkg;

    // Address region after decode
    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_RAM  = 2'd1,
        RG_IO   = 2'd2
    } region_e;

    // Kind of bus cycle, from qualifier and direction
    typedef enum logic [1:0] {
        CYC_DUMMY = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

endpackage

// File: rtl/bbg_bank_latch.sv
module bbg_bank_latch #(
    parameter int DATA_W = 8
) (
    input  logic              phi2,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] bank_q
);

    // Transparent while phi2 is low, closed while phi2 is high.
    always_latch begin
        if (!phi2) begin
            bank_q = d_in;
        end
    end

endmodule

// File: rtl/bbg_decode.sv
module bbg_decode
    import bbg_pkg::*;
#(
    parameter int             DATA_W    = 8,
    parameter int             PAGE_W    = 8,
    parameter int             RAM_BANKS = 8,
    parameter int             IO_BANK   = 0,
    parameter logic [PAGE_W-1:0] IO_PAGE = 8'h7F
) (
    input  logic [DATA_W-1:0] bank,
    input  logic [PAGE_W-1:0] page,
    input  logic              qual,
    output logic              ram_cs_n,
    output logic              io_cs_n
);

    region_e region;
    logic    hit_io;
    logic    hit_ram;

    assign hit_io  = (bank == DATA_W'(IO_BANK)) && (page == IO_PAGE);
    assign hit_ram = (bank < DATA_W'(RAM_BANKS));

    // I/O window takes priority over RAM
    always_comb begin
        if (hit_io) begin
            region = RG_IO;
        end else if (hit_ram) begin
            region = RG_RAM;
        end else begin
            region = RG_NONE;
        end
    end

    always_comb begin
        ram_cs_n = 1'b1;
        io_cs_n  = 1'b1;
        unique case (region)
            RG_RAM:  ram_cs_n = 1'b0;
            RG_IO:   io_cs_n  = !qual;
            RG_NONE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/bbg_strobe.sv
module bbg_strobe
    import bbg_pkg::*;
#(
    parameter bit QUAL_VDA_ONLY = 1'b0
) (
    input  logic phi2,
    input  logic rwb,
    input  logic vda,
    input  logic vpa,
    output logic qual,
    output logic rd_n,
    output logic wr_n
);

    cyc_e cyc;

    generate
        if (QUAL_VDA_ONLY) begin : g_vda_only
            logic unused_vpa;
            assign unused_vpa = vpa;
            assign qual = vda;
        end else begin : g_vda_or_vpa
            assign qual = vda | vpa;
        end
    endgenerate

    always_comb begin
        if (!qual) begin
            cyc = CYC_DUMMY;
        end else if (rwb) begin
            cyc = CYC_READ;
        end else begin
            cyc = CYC_WRITE;
        end
    end

    always_comb begin
        rd_n = 1'b1;
        wr_n = 1'b1;
        unique case (cyc)
            CYC_READ:  rd_n = !phi2;
            CYC_WRITE: wr_n = !phi2;
            CYC_DUMMY: ;
            default:   ;
        endcase
    end

endmodule

// File: rtl/bbg_datapath.sv
module bbg_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              phi2,
    input  logic              rwb,
    input  logic [DATA_W-1:0] cpu_d_in,
    input  logic [DATA_W-1:0] periph_d_in,
    output logic [DATA_W-1:0] cpu_d_out,
    output logic              cpu_d_oe,
    output logic [DATA_W-1:0] periph_d_out,
    output logic              periph_oe,
    output logic              periph_dir_out
);

    assign periph_oe      = phi2;
    assign periph_dir_out = !rwb;
    assign periph_d_out   = cpu_d_in;
    assign cpu_d_out      = periph_d_in;
    assign cpu_d_oe       = phi2 & rwb;

endmodule

// File: rtl/bank_bus_glue.sv
module bank_bus_glue
    import bbg_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int LO_W          = 16,
    parameter int PAGE_W        = 8,
    parameter int RAM_BANKS     = 8,
    parameter int IO_BANK       = 0,
    parameter logic [PAGE_W-1:0] IO_PAGE = 8'h7F,
    parameter bit QUAL_VDA_ONLY = 1'b0
) (
    input  logic                     phi2,
    input  logic                     rwb,
    input  logic                     vda,
    input  logic                     vpa,
    input  logic [LO_W-1:0]          addr_lo,
    input  logic [DATA_W-1:0]        cpu_d_in,
    output logic [DATA_W-1:0]        cpu_d_out,
    output logic                     cpu_d_oe,
    output logic [LO_W+DATA_W-1:0]   addr_out,
    input  logic [DATA_W-1:0]        periph_d_in,
    output logic [DATA_W-1:0]        periph_d_out,
    output logic                     periph_oe,
    output logic                     periph_dir_out,
    output logic                     ram_cs_n,
    output logic                     io_cs_n,
    output logic                     rd_n,
    output logic                     wr_n
);

    localparam int ADDR_W = LO_W + DATA_W;

    logic [DATA_W-1:0] bank_q;
    logic              qual;

    bbg_bank_latch #(.DATA_W(DATA_W)) u_latch (
        .phi2   (phi2),
        .d_in   (cpu_d_in),
        .bank_q (bank_q)
    );

    assign addr_out = {bank_q, addr_lo};

    bbg_strobe #(.QUAL_VDA_ONLY(QUAL_VDA_ONLY)) u_strobe (
        .phi2 (phi2),
        .rwb  (rwb),
        .vda  (vda),
        .vpa  (vpa),
        .qual (qual),
        .rd_n (rd_n),
        .wr_n (wr_n)
    );

    bbg_decode #(
        .DATA_W    (DATA_W),
        .PAGE_W    (PAGE_W),
        .RAM_BANKS (RAM_BANKS),
        .IO_BANK   (IO_BANK),
        .IO_PAGE   (IO_PAGE)
    ) u_decode (
        .bank     (addr_out[ADDR_W-1:LO_W]),
        .page     (addr_out[LO_W-1:LO_W-PAGE_W]),
        .qual     (qual),
        .ram_cs_n (ram_cs_n),
        .io_cs_n  (io_cs_n)
    );

    bbg_datapath #(.DATA_W(DATA_W)) u_path (
        .phi2           (phi2),
        .rwb            (rwb),
        .cpu_d_in       (cpu_d_in),
        .periph_d_in    (periph_d_in),
        .cpu_d_out      (cpu_d_out),
        .cpu_d_oe       (cpu_d_oe),
        .periph_d_out   (periph_d_out),
        .periph_oe      (periph_oe),
        .periph_dir_out (periph_dir_out)
    );

    // Cross-module checks between decode, strobe and data path outputs
    always_comb begin
        a_r6_dummy_quiet: assert (vda || vpa || (io_cs_n && rd_n && wr_n))
            else $error("dummy cycle produced a select or strobe");
        a_r7_one_strobe: assert (rd_n || wr_n)
            else $error("read and write strobes both active");
        a_r8_cs_exclusive: assert (ram_cs_n || io_cs_n)
            else $error("RAM and I/O selected together");
        a_r3_path_phase: assert (phi2 || (!periph_oe && !cpu_d_oe && rd_n && wr_n))
            else $error("data path or strobe active while phi2 low");
        a_r4_dir_matches_strobe: assert (wr_n || periph_dir_out)
            else $error("write strobe with data path toward processor");
    end

endmodule

// File: tb/tb_bank_bus_glue.sv
module tb_bank_bus_glue;

    typedef struct packed {
        logic [23:0] addr;
        logic        ram_cs_n;
        logic        io_cs_n;
        logic        io_cs_n_vda;
        logic        rd_n;
        logic        wr_n;
        logic        p_oe;
        logic        p_dir;
        logic [7:0]  p_out;
        logic        c_oe;
        logic [7:0]  c_out;
    } obs_t;

    logic        clk = 1'b0;
    logic        phi2 = 1'b0;
    logic        rwb = 1'b1;
    logic        vda = 1'b0;
    logic        vpa = 1'b0;
    logic [15:0] addr_lo = 16'h0000;
    logic [7:0]  cpu_d_in = 8'h00;
    logic [7:0]  periph_d_in = 8'h00;

    logic [7:0]  cpu_d_out, periph_d_out, cpu_d_out_v, periph_d_out_v;
    logic        cpu_d_oe, periph_oe, periph_dir_out;
    logic        cpu_d_oe_v, periph_oe_v, periph_dir_out_v;
    logic [23:0] addr_out, addr_out_v;
    logic        ram_cs_n, io_cs_n, rd_n, wr_n;
    logic        ram_cs_n_v, io_cs_n_v, rd_n_v, wr_n_v;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    obs_t  exp_q[$];
    string tag_q[$];
    event  sample_ev;

    always #4 clk = ~clk;

    bank_bus_glue dut (
        .phi2(phi2), .rwb(rwb), .vda(vda), .vpa(vpa), .addr_lo(addr_lo),
        .cpu_d_in(cpu_d_in), .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe),
        .addr_out(addr_out), .periph_d_in(periph_d_in),
        .periph_d_out(periph_d_out), .periph_oe(periph_oe),
        .periph_dir_out(periph_dir_out), .ram_cs_n(ram_cs_n),
        .io_cs_n(io_cs_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    bank_bus_glue #(.QUAL_VDA_ONLY(1'b1)) dut_vda (
        .phi2(phi2), .rwb(rwb), .vda(vda), .vpa(vpa), .addr_lo(addr_lo),
        .cpu_d_in(cpu_d_in), .cpu_d_out(cpu_d_out_v), .cpu_d_oe(cpu_d_oe_v),
        .addr_out(addr_out_v), .periph_d_in(periph_d_in),
        .periph_d_out(periph_d_out_v), .periph_oe(periph_oe_v),
        .periph_dir_out(periph_dir_out_v), .ram_cs_n(ram_cs_n_v),
        .io_cs_n(io_cs_n_v), .rd_n(rd_n_v), .wr_n(wr_n_v)
    );

    // Expected outputs, from the requirements
    function automatic obs_t expect_of(input logic ph, input logic [7:0] bank,
                                       input logic [15:0] a, input logic v_d,
                                       input logic v_p, input logic rw,
                                       input logic [7:0] dcur, input logic [7:0] pd);
        obs_t e;
        logic q, qv, win, ram;
        q   = v_d | v_p;
        qv  = v_d;
        win = (bank == 8'h00) && (a[15:8] == 8'h7F);
        ram = (bank < 8'h08) && !win;
        e.addr        = {bank, a};
        e.ram_cs_n    = !ram;
        e.io_cs_n     = !(win && q);
        e.io_cs_n_vda = !(win && qv);
        e.rd_n        = !(ph && q && rw);
        e.wr_n        = !(ph && q && !rw);
        e.p_oe        = ph;
        e.p_dir       = !rw;
        e.p_out       = dcur;
        e.c_oe        = ph && rw;
        e.c_out       = pd;
        return e;
    endfunction

    task automatic push_and_sample(input obs_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #1;
        -> sample_ev;
    endtask

    // One processor bus cycle: low phase, high phase, then high phase with data bus changed
    task automatic bus_cycle(input logic [7:0] bank, input logic [15:0] a,
                             input logic v_d, input logic v_p, input logic rw,
                             input logic [7:0] wd, input logic [7:0] pd,
                             input string tag);
        logic [7:0] late;
        @(negedge clk);
        phi2 = 1'b0; cpu_d_in = bank; addr_lo = a; vda = v_d; vpa = v_p;
        rwb = rw; periph_d_in = pd;
        push_and_sample(expect_of(1'b0, bank, a, v_d, v_p, rw, bank, pd),
                        {tag, " low-phase R1 R3 R9 R10"});
        @(negedge clk);
        phi2 = 1'b1;
        push_and_sample(expect_of(1'b1, bank, a, v_d, v_p, rw, bank, pd),
                        {tag, " high-phase R3 R4 R5 R6 R7 R8"});
        @(negedge clk);
        late = rw ? 8'hEE : wd;
        cpu_d_in = late;
        push_and_sample(expect_of(1'b1, bank, a, v_d, v_p, rw, late, pd),
                        {tag, " held-bank R2 R4"});
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            obs_t  e, g;
            string t;
            @(sample_ev);
            g = '{addr_out, ram_cs_n, io_cs_n, io_cs_n_v, rd_n, wr_n,
                  periph_oe, periph_dir_out, periph_d_out, cpu_d_oe, cpu_d_out};
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (g !== e) begin
                n_errors++;
                $display("FAIL %s: actual=%h expected=%h", t, g, e);
            end
        end
    end

    initial begin
        // Idle after power-up: dummy cycle, no reset applied (R10, R6)
        bus_cycle(8'h03, 16'h1234, 1'b0, 1'b0, 1'b1, 8'h00, 8'h5A, "R10 first-cycle dummy");
        // RAM data read (R8, R7)
        bus_cycle(8'h05, 16'hA000, 1'b1, 1'b0, 1'b1, 8'h00, 8'hC3, "R8 ram-read");
        // I/O read qualified by vda (R5)
        bus_cycle(8'h00, 16'h7F10, 1'b1, 1'b0, 1'b1, 8'h00, 8'h81, "R5 io-read-vda");
        // I/O access qualified by vpa only: OR mode selects, vda-only mode does not (R5)
        bus_cycle(8'h00, 16'h7F20, 1'b0, 1'b1, 1'b1, 8'h00, 8'h42, "R5 io-vpa-only");
        // Dummy cycle at I/O address, read and write direction (R6)
        bus_cycle(8'h00, 16'h7F04, 1'b0, 1'b0, 1'b1, 8'h00, 8'h99, "R6 dummy-io-read");
        bus_cycle(8'h00, 16'h7F04, 1'b0, 1'b0, 1'b0, 8'h77, 8'h99, "R6 dummy-io-write");
        // Back-to-back writes to I/O (R9, R4)
        bus_cycle(8'h00, 16'h7F02, 1'b1, 1'b0, 1'b0, 8'h11, 8'h00, "R9 write-1");
        bus_cycle(8'h00, 16'h7F02, 1'b1, 1'b0, 1'b0, 8'h22, 8'h00, "R9 write-2");
        // Map boundaries (R8)
        bus_cycle(8'h00, 16'h7EFF, 1'b1, 1'b0, 1'b1, 8'h00, 8'h10, "R8 below-window");
        bus_cycle(8'h00, 16'h8000, 1'b1, 1'b0, 1'b1, 8'h00, 8'h20, "R8 above-window");
        bus_cycle(8'h01, 16'h7F00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h30, "R8 bank1-window-page");
        bus_cycle(8'h07, 16'hFFFF, 1'b1, 1'b0, 1'b0, 8'h44, 8'h00, "R8 top-ram");
        bus_cycle(8'h08, 16'h0000, 1'b1, 1'b0, 1'b1, 8'h00, 8'h50, "R8 unmapped-bank8");
        bus_cycle(8'hFF, 16'h7F00, 1'b1, 1'b1, 1'b0, 8'h66, 8'h00, "R8 unmapped-bankFF");
        // RAM write with both qualifiers (R7)
        bus_cycle(8'h02, 16'h0100, 1'b1, 1'b1, 1'b0, 8'hA5, 8'h00, "R7 ram-write");
        @(negedge clk);
        phi2 = 1'b0;
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule